// File: doc/BRIEF.md
# Two-Wire Debug Entry Sequencer

This block produces the pin waveform that moves a target's test logic into two-wire serial debug mode. It drives two lines: a test/clock line and a reset/data line. Each line has its own output enable. A one-cycle start pulse launches a fixed series of seven timed phases. First the test logic is reset with the clock line low. Next the clock line is raised and held to activate the logic. The data line then signals the two-wire request. A short low pulse on the clock line latches that request. Two settling waits close the sequence.

Every phase length is given in microseconds and turned into system-clock cycles by a packaged function. The function rounds the result up. A single down-counter times all phases and is reloaded at each phase change.

When the sequence ends, the block raises a one-cycle done pulse. It then keeps both lines driven high until the serial transport that follows asserts its take-over input. At that point both output enables drop.

Top module: `dbg2w_entry_seq`

## Requirements
- R1: After reset both output enables, both pin levels, busy and done are 0.
- R2: A start pulse seen while idle starts the reset phase on the next cycle. In this phase the clock line is 0, the data line is 1, and both are enabled. It lasts the cycle count of T_RESET_US.
- R3: A setup phase follows with the same pin levels. It lasts the cycle count of T_SETUP_US.
- R4: In the activation phase the clock line is 1 and the data line is 1. It lasts the cycle count of T_ACT_US.
- R5: In the request phase the data line is 1 and the clock line is 1. It lasts the cycle count of T_REQ_US.
- R6: In the latch phase the clock line is 0 and the data line is 1. It lasts the cycle count of T_LATCH_US. That count is at least one cycle and at most the cycle count of 7 µs.
- R7: In the hold phase, and then the settle phase, both lines are 1. They last the cycle counts of T_HOLD_US and T_SETTLE_US.
- R8: Each phase lasts exactly ceil(us × CLK_HZ / 1 000 000) cycles, and never less than one cycle.
- R9: Busy is 1 from the first cycle of the reset phase through the last cycle of the settle phase, and 0 at all other times.
- R10: Done is 1 for exactly one cycle: the first cycle after the settle phase.
- R11: A start pulse while busy is ignored. The phase timing is unchanged.
- R12: After done, both lines stay enabled and at 1 until the take-over input is asserted. On the cycle after that input, both enables are 0. The take-over input has no effect while busy.
- R13: A start pulse while the lines are held after done starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| takeover_i | input | 1 | Transport engine claims the pins |
| tck_o | output | 1 | Test/clock line level |
| tck_oe_o | output | 1 | Test/clock line output enable |
| tdio_o | output | 1 | Reset/data line level |
| tdio_oe_o | output | 1 | Reset/data line output enable |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CLK_HZ = 2 500 000. At that rate one microsecond is 2.5 cycles, so a 1 µs phase must come out as 3 cycles. Truncation would give 2, so this setting exposes it. The bench also shrinks the phase durations to a few microseconds each. This brings a full sequence down to 111 cycles. Two complete runs then fit in the bench, along with ignored start and take-over pulses, a restart from the held state, and mid-sequence reset.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

  typedef enum logic [3:0] {
    PH_IDLE     = 4'd0,
    PH_RESET    = 4'd1,
    PH_SETUP    = 4'd2,
    PH_ACTIVATE = 4'd3,
    PH_REQUEST  = 4'd4,
    PH_LATCH    = 4'd5,
    PH_HOLD     = 4'd6,
    PH_SETTLE   = 4'd7,
    PH_READY    = 4'd8
  } phase_e;

  // Microseconds to clock cycles, rounded up, at least one cycle.
  function automatic int unsigned us_to_cycles(longint unsigned us, longint unsigned hz);
    longint unsigned c;
    c = (us * hz + 64'd999_999) / 64'd1_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic phase_e next_phase(phase_e ph);
    case (ph)
      PH_RESET:    return PH_SETUP;
      PH_SETUP:    return PH_ACTIVATE;
      PH_ACTIVATE: return PH_REQUEST;
      PH_REQUEST:  return PH_LATCH;
      PH_LATCH:    return PH_HOLD;
      PH_HOLD:     return PH_SETTLE;
      PH_SETTLE:   return PH_READY;
      default:     return ph;
    endcase
  endfunction

  function automatic logic phase_running(phase_e ph);
    return (ph != PH_IDLE) && (ph != PH_READY);
  endfunction

endpackage

// File: rtl/dbg2w_phase_timer.sv
module dbg2w_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] elapsed_o
);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q  <= '0;
      elapsed_q <= '0;
      len_q     <= '0;
    end else if (load_i) begin
      remain_q  <= len_i - CNT_W'(1);
      elapsed_q <= '0;
      len_q     <= len_i;
    end else if (run_i) begin
      if (remain_q != '0) remain_q <= remain_q - CNT_W'(1);
      elapsed_q <= elapsed_q + CNT_W'(1);
    end
  end

  assign expire_o  = run_i && (remain_q == '0);
  assign elapsed_o = elapsed_q;

  // R8: a phase ends after exactly the loaded number of cycles
  assert_phase_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (elapsed_q + CNT_W'(1) == len_q));

endmodule

// File: rtl/dbg2w_phase_fsm.sv
module dbg2w_phase_fsm
  import dbg2w_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned CYC_RESET  = 1,
  parameter int unsigned CYC_SETUP  = 1,
  parameter int unsigned CYC_ACT    = 1,
  parameter int unsigned CYC_REQ    = 1,
  parameter int unsigned CYC_LATCH  = 1,
  parameter int unsigned CYC_HOLD   = 1,
  parameter int unsigned CYC_SETTLE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             takeover_i,
  input  logic             expire_i,
  output phase_e           phase_o,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             done_o
);

  phase_e phase_q, phase_d;
  logic   done_q;
  logic   running;
  logic   accept_start;
  logic   advance;

  function automatic logic [CNT_W-1:0] phase_len(phase_e ph);
    case (ph)
      PH_RESET:    return CNT_W'(CYC_RESET);
      PH_SETUP:    return CNT_W'(CYC_SETUP);
      PH_ACTIVATE: return CNT_W'(CYC_ACT);
      PH_REQUEST:  return CNT_W'(CYC_REQ);
      PH_LATCH:    return CNT_W'(CYC_LATCH);
      PH_HOLD:     return CNT_W'(CYC_HOLD);
      PH_SETTLE:   return CNT_W'(CYC_SETTLE);
      default:     return CNT_W'(1);
    endcase
  endfunction

  assign running      = phase_running(phase_q);
  assign accept_start = start_i && !running;
  assign advance      = running && expire_i;

  always_comb begin
    phase_d = phase_q;
    if (accept_start)                                phase_d = PH_RESET;
    else if (advance)                                phase_d = next_phase(phase_q);
    else if (phase_q == PH_READY && takeover_i)      phase_d = PH_IDLE;
  end

  assign load_o = accept_start || (advance && phase_running(next_phase(phase_q)));
  assign len_o  = phase_len(phase_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= advance && (phase_q == PH_SETTLE);
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  // R11: a start while busy leaves the phase untouched
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_i && !expire_i) |=> (phase_q == $past(phase_q)));

  // R10: done never lasts two cycles
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: done is always followed by the ready state
  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_READY));

  // R12: take-over during a run does not end it early
  assert_takeover_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (running && takeover_i && !expire_i && !start_i) |=> (phase_q == $past(phase_q)));

endmodule

// File: rtl/dbg2w_pin_decode.sv
module dbg2w_pin_decode
  import dbg2w_pkg::*;
(
  input  phase_e phase_i,
  output logic   tck_o,
  output logic   tck_oe_o,
  output logic   tdio_o,
  output logic   tdio_oe_o,
  output logic   busy_o
);

  // {tck, tdio, enabled}
  function automatic logic [2:0] pin_levels(phase_e ph);
    case (ph)
      PH_RESET, PH_SETUP, PH_LATCH:                 return 3'b011;
      PH_ACTIVATE, PH_REQUEST, PH_HOLD, PH_SETTLE,
      PH_READY:                                     return 3'b111;
      default:                                      return 3'b000;
    endcase
  endfunction

  logic [2:0] lv;
  assign lv        = pin_levels(phase_i);
  assign tck_o     = lv[2];
  assign tdio_o    = lv[1];
  assign tck_oe_o  = lv[0];
  assign tdio_oe_o = lv[0];
  assign busy_o    = phase_running(phase_i);

endmodule

// File: rtl/dbg2w_entry_seq.sv
module dbg2w_entry_seq
  import dbg2w_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned     T_RESET_US  = 4000,
  parameter int unsigned     T_SETUP_US  = 1,
  parameter int unsigned     T_ACT_US    = 20000,
  parameter int unsigned     T_REQ_US    = 60,
  parameter int unsigned     T_LATCH_US  = 1,
  parameter int unsigned     T_HOLD_US   = 60,
  parameter int unsigned     T_SETTLE_US = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic takeover_i,
  output logic tck_o,
  output logic tck_oe_o,
  output logic tdio_o,
  output logic tdio_oe_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CYC_RESET  = us_to_cycles(T_RESET_US,  CLK_HZ);
  localparam int unsigned CYC_SETUP  = us_to_cycles(T_SETUP_US,  CLK_HZ);
  localparam int unsigned CYC_ACT    = us_to_cycles(T_ACT_US,    CLK_HZ);
  localparam int unsigned CYC_REQ    = us_to_cycles(T_REQ_US,    CLK_HZ);
  localparam int unsigned CYC_LATCH  = us_to_cycles(T_LATCH_US,  CLK_HZ);
  localparam int unsigned CYC_HOLD   = us_to_cycles(T_HOLD_US,   CLK_HZ);
  localparam int unsigned CYC_SETTLE = us_to_cycles(T_SETTLE_US, CLK_HZ);
  localparam int unsigned CYC_LATCH_MAX = us_to_cycles(7, CLK_HZ);

  localparam int unsigned MAX_A   = (CYC_RESET > CYC_ACT) ? CYC_RESET : CYC_ACT;
  localparam int unsigned MAX_B   = (CYC_SETTLE > CYC_REQ) ? CYC_SETTLE : CYC_REQ;
  localparam int unsigned MAX_C   = (CYC_HOLD > CYC_SETUP) ? CYC_HOLD : CYC_SETUP;
  localparam int unsigned MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 2);

  phase_e           phase;
  logic             load;
  logic [CNT_W-1:0] len;
  logic             expire;
  logic [CNT_W-1:0] elapsed;
  logic             running;

  dbg2w_phase_fsm #(
    .CNT_W(CNT_W), .CYC_RESET(CYC_RESET), .CYC_SETUP(CYC_SETUP),
    .CYC_ACT(CYC_ACT), .CYC_REQ(CYC_REQ), .CYC_LATCH(CYC_LATCH),
    .CYC_HOLD(CYC_HOLD), .CYC_SETTLE(CYC_SETTLE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .takeover_i(takeover_i),
    .expire_i(expire), .phase_o(phase), .load_o(load), .len_o(len),
    .done_o(done_o)
  );

  assign running = phase_running(phase);

  dbg2w_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .len_i(len), .run_i(running),
    .expire_o(expire), .elapsed_o(elapsed)
  );

  dbg2w_pin_decode u_pins (
    .phase_i(phase), .tck_o(tck_o), .tck_oe_o(tck_oe_o), .tdio_o(tdio_o),
    .tdio_oe_o(tdio_oe_o), .busy_o(busy_o)
  );

  // R6: latch pulse stays inside its allowed window
  initial assert_latch_window_R6: assert (CYC_LATCH >= 1 && CYC_LATCH <= CYC_LATCH_MAX);

  // R6: the low pulse on the clock line never runs past 7 us
  assert_latch_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LATCH) |-> (!tck_o && elapsed < CNT_W'(CYC_LATCH_MAX)));

  // R9: while busy both lines are driven
  assert_busy_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (tck_oe_o && tdio_oe_o));

  // R12: after done the lines are held high and enabled
  assert_ready_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tck_o && tdio_o && tck_oe_o && tdio_oe_o && !busy_o));

  // R2: an accepted start leads into the reset phase
  assert_start_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !tck_o && tdio_o));

endmodule

// File: tb/dbg2w_entry_seq_test.sv
module dbg2w_entry_seq_test;

  localparam longint unsigned HZ = 2_500_000;
  localparam int NROW = 7;
  localparam int ROW_US [NROW] = '{8, 1, 12, 6, 1, 6, 10};
  // expected {tck, tdio} per row
  localparam logic [1:0] ROW_PIN [NROW] = '{2'b01, 2'b01, 2'b11, 2'b11, 2'b01, 2'b11, 2'b11};
  localparam string ROW_TAG [NROW] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R7"};

  logic clk = 0, rst_n = 0, start_i = 0, takeover_i = 0;
  logic tck_o, tck_oe_o, tdio_o, tdio_oe_o, busy_o, done_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dbg2w_entry_seq #(
    .CLK_HZ(HZ), .T_RESET_US(8), .T_SETUP_US(1), .T_ACT_US(12),
    .T_REQ_US(6), .T_LATCH_US(1), .T_HOLD_US(6), .T_SETTLE_US(10)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .takeover_i(takeover_i),
    .tck_o(tck_o), .tck_oe_o(tck_oe_o), .tdio_o(tdio_o), .tdio_oe_o(tdio_oe_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int ceil_cycles(int us);
    int c;
    c = (us * 5 + 1) / 2;  // 2.5 cycles per microsecond, rounded up
    return (c < 1) ? 1 : c;
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pins();
    return {tck_o, tdio_o, tck_oe_o, tdio_oe_o, busy_o, done_o};
  endfunction

  // Walks the vector table; optional stray pulses inside a given row.
  task automatic run_sequence(int poke_row, bit poke_start, bit poke_take);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int r = 0; r < NROW; r++) begin
      int n;
      int bad;
      logic [5:0] first_bad;
      logic [5:0] exp;
      n = ceil_cycles(ROW_US[r]);
      bad = 0;
      first_bad = '0;
      exp = {ROW_PIN[r], 2'b11, 1'b1, 1'b0};
      for (int k = 0; k < n; k++) begin
        if (pins() !== exp && bad == 0) begin
          bad = 1;
          first_bad = pins();
        end
        if (r == poke_row && k == 1) begin
          start_i = poke_start;
          takeover_i = poke_take;
        end else begin
          start_i = 0;
          takeover_i = 0;
        end
        @(negedge clk);
      end
      start_i = 0;
      takeover_i = 0;
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL %s/R8 row %0d actual=%b expected=%b", ROW_TAG[r], r, first_bad, exp);
      end
    end
    // R10 R9: first cycle after settle
    check("R10", pins(), 6'b111101);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    check("R1", pins(), 6'b000000);
    rst_n = 1;
    @(negedge clk);
    check("R1", pins(), 6'b000000);

    // R12: take-over while idle has no effect
    takeover_i = 1;
    @(negedge clk);
    takeover_i = 0;
    check("R12", pins(), 6'b000000);

    // R2..R8: full sequence, with a start pulse in activation (R11)
    run_sequence(2, 1'b1, 1'b0);
    @(negedge clk);
    check("R10", pins(), 6'b111100);
    repeat (5) @(negedge clk);
    check("R12", pins(), 6'b111100);

    // R13: restart from the held state, with take-over poked mid-run (R12)
    run_sequence(4, 1'b0, 1'b1);
    @(negedge clk);
    check("R11", pins(), 6'b111100);

    // R12: take-over releases the lines on the next cycle
    takeover_i = 1;
    @(negedge clk);
    takeover_i = 0;
    check("R12", pins(), 6'b000000);
    repeat (3) @(negedge clk);
    check("R12", pins(), 6'b000000);

    // R13: start from idle again, then reset mid-sequence (R1)
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    check("R13", pins(), 6'b011110);
    repeat (30) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R1", pins(), 6'b000000);
    rst_n = 1;
    @(negedge clk);
    check("R1", pins(), 6'b000000);

    // R9: start and busy on the very next cycle
    run_sequence(-1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule